// File: doc/BRIEF.md
# Adaptive Delta Modulation Codec

This block turns a stream of signed samples into a one-bit-per-sample stream and rebuilds a staircase copy of the signal from that stream. The encoder half compares each accepted sample with its own running estimate and sends a 1 when the sample lies strictly above the estimate and a 0 otherwise. Each sent bit then moves the estimate up (1) or down (0) by an adaptive step.

The step is a fixed unit multiplied by a level between 1 and `STAGES`. The level is held as a thermometer code whose lowest stage is always on. A bit equal to the one before it switches one more stage on, which lets the estimate catch a steep slope. A bit that differs from the one before it switches one stage off, which damps the hunting around a slow input. The decoder half runs the same adaptation from the received bits alone, so a clean channel gives the same estimate on both sides. Both estimates saturate at the signed limits of the accumulator.

In use, `bit_out`/`bit_out_valid` feed a channel, and the far end presents the bits on `bit_in`/`bit_in_valid`. A reconstruction filter, if one is wanted, follows `recon_out`.

Top module: `adm_codec`

## Requirements
- R1: One clock edge after a sample is accepted (`smp_valid` high), `bit_out` is 1 if the sign-extended sample is strictly greater than `approx_out`, and 0 if it is equal or lower. `bit_out_valid` is high for exactly that cycle.
- R2: A bit presented to the encoder's step stage moves `approx_out` on the next edge, so the move lands two edges after the sample. A 1 adds the step and a 0 subtracts it.
- R3: The step equals `UNIT` times the number of active thermometer stages. This number is always between 1 and `STAGES`. Right after reset a first bit of 1 moves the estimate by exactly `UNIT`.
- R4: When a bit equals the previous bit, the stage count rises by one, up to a limit of `STAGES`. When it differs, the count falls by one, down to a limit of 1. The new count is the one used for that bit's step. The stored previous bit resets to 0.
- R5: The estimates clamp at +2^(ACC_W-1)-1 and -2^(ACC_W-1) and never wrap.
- R6: `recon_out` follows the same rules as R2–R5 from `bit_in` alone. It changes on the edge after `bit_in_valid` is sampled high and is constant in every cycle where `bit_in_valid` is low. Given the same bits at the same time, it equals `approx_out`.
- R7: While `smp_valid` is low, `bit_out_valid` drops to 0 one edge later and `approx_out` stays frozen from then on.
- R8: A synchronous reset makes both estimates 0, both stage counts 1, both previous bits 0 and `bit_out_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_in | input | SAMPLE_W | Signed input sample |
| bit_out | output | 1 | Encoded bit |
| bit_out_valid | output | 1 | Encoded bit is new this cycle |
| approx_out | output | ACC_W | Encoder's running estimate (signed) |
| bit_in | input | 1 | Received bit |
| bit_in_valid | input | 1 | Received bit strobe |
| recon_out | output | ACC_W | Decoder's registered reconstruction (signed) |

## Verification
The encoded bit is due one edge after the sample edge, and the encoder estimate moves one edge after that. The decoder estimate moves one edge after its bit strobe. The bench drives inputs on the falling edge, advances its own encoder and decoder models at the rising edge in that order, and compares all outputs 1 ns after the edge. The comparison uses the estimate from before the update, matching the two-edge latency. Saturation, equal-value comparison, idle gaps and mid-run reset are checked at the exact edge where each takes effect.

// File: rtl/adm_pkg.sv
package adm_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } adm_dir_e;

    localparam int DEF_SAMPLE_W = 12;
    localparam int DEF_ACC_W    = 14;
    localparam int DEF_STAGES   = 8;
    localparam int DEF_UNIT     = 16;

endpackage

// File: rtl/adm_step_ctrl.sv
module adm_step_ctrl #(
    parameter  int STAGES = adm_pkg::DEF_STAGES,
    parameter  int UNIT   = adm_pkg::DEF_UNIT,
    parameter  int ACC_W  = adm_pkg::DEF_ACC_W,
    localparam int CNT_W  = $clog2(STAGES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic             bit_i,
    output logic [ACC_W-1:0] step_o
);

    typedef struct packed {
        logic [STAGES-1:0] therm;
        logic [CNT_W-1:0]  count;
        logic              prev;
    } st_t;

    st_t st_d, st_q;
    logic [STAGES-1:0] grow_v, shrink_v;
    logic [CNT_W-1:0]  cnt_d;

    // Thermometer neighbours: grow shifts in a one, shrink drops the top stage.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_floor
            assign grow_v[g]   = 1'b1;
            assign shrink_v[g] = 1'b1;
        end else if (g == STAGES - 1) begin : g_top
            assign grow_v[g]   = st_q.therm[g-1];
            assign shrink_v[g] = 1'b0;
        end else begin : g_mid
            assign grow_v[g]   = st_q.therm[g-1];
            assign shrink_v[g] = st_q.therm[g+1];
        end
    end

    always_comb begin
        st_d = st_q;
        if (upd) begin
            st_d.therm = (bit_i == st_q.prev) ? grow_v : shrink_v;
            st_d.prev  = bit_i;
        end
        cnt_d = '0;
        for (int i = 0; i < STAGES; i++) begin
            cnt_d = cnt_d + CNT_W'(st_d.therm[i]);
        end
        st_d.count = cnt_d;
        step_o     = ACC_W'(cnt_d) * ACC_W'(UNIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.therm <= STAGES'(1);
            st_q.count <= CNT_W'(1);
            st_q.prev  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: lowest stage never switches off, and the level stays inside 1..STAGES
    a_r3_floor_stage: assert property (@(posedge clk) disable iff (rst)
        st_q.therm[0] == 1'b1);
    a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
        (st_q.count >= CNT_W'(1)) && (st_q.count <= CNT_W'(STAGES)));
    // R4: a repeated bit adds one stage below the limit
    a_r4_grow: assert property (@(posedge clk) disable iff (rst)
        upd && (bit_i == st_q.prev) && (st_q.count < CNT_W'(STAGES))
        |=> st_q.count == $past(st_q.count) + CNT_W'(1));
    // R4: a changed bit removes one stage above the floor
    a_r4_shrink: assert property (@(posedge clk) disable iff (rst)
        upd && (bit_i != st_q.prev) && (st_q.count > CNT_W'(1))
        |=> st_q.count == $past(st_q.count) - CNT_W'(1));
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(st_q.therm));

endmodule

// File: rtl/adm_accum.sv
module adm_accum #(
    parameter int ACC_W = adm_pkg::DEF_ACC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd,
    input  adm_pkg::adm_dir_e       dir_i,
    input  logic        [ACC_W-1:0] step_i,
    output logic signed [ACC_W-1:0] approx_o
);

    localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [ACC_W:0]   WMAX = {1'b0, MAXV};
    localparam logic signed [ACC_W:0]   WMIN = {1'b1, MINV};

    typedef struct packed {
        logic signed [ACC_W-1:0] approx;
    } st_t;

    st_t st_d, st_q;
    logic signed [ACC_W:0] wide_a, wide_s, sum;

    always_comb begin
        st_d   = st_q;
        wide_a = {st_q.approx[ACC_W-1], st_q.approx};
        wide_s = {1'b0, step_i};
        sum    = (dir_i == adm_pkg::DIR_UP) ? (wide_a + wide_s) : (wide_a - wide_s);
        if (upd) begin
            if (sum > WMAX) begin
                st_d.approx = MAXV;
            end else if (sum < WMIN) begin
                st_d.approx = MINV;
            end else begin
                st_d.approx = sum[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.approx <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign approx_o = st_q.approx;

    // R2: an up move below the ceiling raises the estimate, a down move above the floor lowers it
    a_r2_rise: assert property (@(posedge clk) disable iff (rst)
        upd && (dir_i == adm_pkg::DIR_UP) && (approx_o != MAXV)
        |=> approx_o > $past(approx_o));
    a_r2_fall: assert property (@(posedge clk) disable iff (rst)
        upd && (dir_i == adm_pkg::DIR_DOWN) && (approx_o != MINV)
        |=> approx_o < $past(approx_o));
    // R5: a pinned estimate stays pinned instead of wrapping
    a_r5_no_wrap_hi: assert property (@(posedge clk) disable iff (rst)
        upd && (dir_i == adm_pkg::DIR_UP) && (approx_o == MAXV) |=> approx_o == MAXV);
    a_r5_no_wrap_lo: assert property (@(posedge clk) disable iff (rst)
        upd && (dir_i == adm_pkg::DIR_DOWN) && (approx_o == MINV) |=> approx_o == MINV);
    // R7: no update, no movement
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(approx_o));

endmodule

// File: rtl/adm_modulator.sv
module adm_modulator #(
    parameter  int SAMPLE_W = adm_pkg::DEF_SAMPLE_W,
    parameter  int ACC_W    = adm_pkg::DEF_ACC_W,
    parameter  int STAGES   = adm_pkg::DEF_STAGES,
    parameter  int UNIT     = adm_pkg::DEF_UNIT,
    localparam int EXT_W    = ACC_W - SAMPLE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_in,
    output logic                       bit_o,
    output logic                       bit_valid_o,
    output logic signed [ACC_W-1:0]    approx_o
);

    typedef struct packed {
        logic bit_v;
        logic valid;
    } st_t;

    st_t st_d, st_q;
    logic signed [ACC_W-1:0] smp_ext;
    logic        [ACC_W-1:0] step;

    assign smp_ext = {{EXT_W{smp_in[SAMPLE_W-1]}}, smp_in};

    always_comb begin
        st_d       = st_q;
        st_d.valid = smp_valid;
        if (smp_valid) begin
            st_d.bit_v = (smp_ext > approx_o);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.bit_v <= 1'b0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    adm_step_ctrl #(.STAGES(STAGES), .UNIT(UNIT), .ACC_W(ACC_W)) u_step (
        .clk    (clk),
        .rst    (rst),
        .upd    (st_q.valid),
        .bit_i  (st_q.bit_v),
        .step_o (step)
    );

    adm_accum #(.ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .upd      (st_q.valid),
        .dir_i    (adm_pkg::adm_dir_e'(st_q.bit_v)),
        .step_i   (step),
        .approx_o (approx_o)
    );

    assign bit_o       = st_q.bit_v;
    assign bit_valid_o = st_q.valid;

    // R1: decision against the estimate seen at the sampling edge
    a_r1_above: assert property (@(posedge clk) disable iff (rst)
        smp_valid && (smp_ext > approx_o) |=> bit_o && bit_valid_o);
    a_r1_not_above: assert property (@(posedge clk) disable iff (rst)
        smp_valid && (smp_ext <= approx_o) |=> !bit_o && bit_valid_o);
    // R7: no strobe, no new bit
    a_r7_no_bit: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !bit_valid_o);

endmodule

// File: rtl/adm_demodulator.sv
module adm_demodulator #(
    parameter int ACC_W  = adm_pkg::DEF_ACC_W,
    parameter int STAGES = adm_pkg::DEF_STAGES,
    parameter int UNIT   = adm_pkg::DEF_UNIT
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_valid_i,
    input  logic                    bit_i,
    output logic signed [ACC_W-1:0] recon_o
);

    logic [ACC_W-1:0] step;

    adm_step_ctrl #(.STAGES(STAGES), .UNIT(UNIT), .ACC_W(ACC_W)) u_step (
        .clk    (clk),
        .rst    (rst),
        .upd    (bit_valid_i),
        .bit_i  (bit_i),
        .step_o (step)
    );

    adm_accum #(.ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .upd      (bit_valid_i),
        .dir_i    (adm_pkg::adm_dir_e'(bit_i)),
        .step_i   (step),
        .approx_o (recon_o)
    );

    // R6: reconstruction frozen between received bits
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_valid_i |=> $stable(recon_o));
    a_r6_moves: assert property (@(posedge clk) disable iff (rst)
        bit_valid_i && bit_i && !$past(rst) |=> recon_o >= $past(recon_o));

endmodule

// File: rtl/adm_codec.sv
module adm_codec #(
    parameter int SAMPLE_W = adm_pkg::DEF_SAMPLE_W,
    parameter int ACC_W    = adm_pkg::DEF_ACC_W,
    parameter int STAGES   = adm_pkg::DEF_STAGES,
    parameter int UNIT     = adm_pkg::DEF_UNIT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_in,
    output logic                       bit_out,
    output logic                       bit_out_valid,
    output logic signed [ACC_W-1:0]    approx_out,
    input  logic                       bit_in,
    input  logic                       bit_in_valid,
    output logic signed [ACC_W-1:0]    recon_out
);

    adm_modulator #(
        .SAMPLE_W (SAMPLE_W),
        .ACC_W    (ACC_W),
        .STAGES   (STAGES),
        .UNIT     (UNIT)
    ) u_mod (
        .clk         (clk),
        .rst         (rst),
        .smp_valid   (smp_valid),
        .smp_in      (smp_in),
        .bit_o       (bit_out),
        .bit_valid_o (bit_out_valid),
        .approx_o    (approx_out)
    );

    adm_demodulator #(
        .ACC_W  (ACC_W),
        .STAGES (STAGES),
        .UNIT   (UNIT)
    ) u_demod (
        .clk         (clk),
        .rst         (rst),
        .bit_valid_i (bit_in_valid),
        .bit_i       (bit_in),
        .recon_o     (recon_out)
    );

    // R8: reset leaves both estimates at zero on the next edge
    a_r8_reset_zero: assert property (@(posedge clk)
        rst |=> (approx_out == '0) && (recon_out == '0) && !bit_out_valid);

endmodule

// File: tb/adm_codec_bench.sv
module adm_codec_bench;

    localparam int SW   = 12;
    localparam int AW   = 14;
    localparam int STG  = 8;
    localparam int UNIT = 16;
    localparam int MAXA = 8191;
    localparam int MINA = -8192;
    localparam int NVEC = 20;

    // {valid, sample}
    localparam logic [SW:0] VEC [NVEC] = '{
        {1'b1, 12'd1000}, {1'b1, 12'd1000}, {1'b1, 12'd1000}, {1'b1, 12'd1000},
        {1'b1, 12'd1000}, {1'b1, 12'd1000}, {1'b0, 12'd0},    {1'b0, 12'd0},
        {1'b1, 12'd1500}, {1'b1, 12'd1500}, {1'b1, 12'hCE0},  {1'b1, 12'hCE0},
        {1'b1, 12'hCE0},  {1'b1, 12'hCE0},  {1'b1, 12'hCE0},  {1'b0, 12'd5},
        {1'b1, 12'd3},    {1'b1, 12'd3},    {1'b1, 12'hFFF},  {1'b1, 12'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic signed [SW-1:0] smp_in = '0;
    logic bit_out, bit_out_valid;
    logic signed [AW-1:0] approx_out, recon_out;
    logic loop_en = 1'b1;
    logic drv_v = 1'b0;
    logic drv_b = 1'b0;
    logic bit_in, bit_in_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // encoder model
    int   m_cnt, m_acc;
    logic m_prev, m_bit, m_txv;
    // decoder model
    int   d_cnt, d_acc;
    logic d_prev;

    assign bit_in       = loop_en ? bit_out       : drv_b;
    assign bit_in_valid = loop_en ? bit_out_valid : drv_v;

    always #2 clk = ~clk;

    adm_codec #(.SAMPLE_W(SW), .ACC_W(AW), .STAGES(STG), .UNIT(UNIT)) u_adm_codec (
        .clk           (clk),
        .rst           (rst),
        .smp_valid     (smp_valid),
        .smp_in        (smp_in),
        .bit_out       (bit_out),
        .bit_out_valid (bit_out_valid),
        .approx_out    (approx_out),
        .bit_in        (bit_in),
        .bit_in_valid  (bit_in_valid),
        .recon_out     (recon_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic apply(inout int cnt, inout logic prev, inout int acc, input logic b);
        if (b == prev) cnt = (cnt < STG) ? cnt + 1 : cnt;
        else           cnt = (cnt > 1)   ? cnt - 1 : cnt;
        prev = b;
        acc  = b ? acc + cnt * UNIT : acc - cnt * UNIT;
        if (acc > MAXA) acc = MAXA;
        if (acc < MINA) acc = MINA;
    endtask

    task automatic model_reset();
        m_cnt = 1; m_acc = 0; m_prev = 1'b0; m_bit = 1'b0; m_txv = 1'b0;
        d_cnt = 1; d_acc = 0; d_prev = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_valid = 1'b0; drv_v = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        model_reset();
        chk("R8 approx", int'(approx_out), 0);
        chk("R8 recon", int'(recon_out), 0);
        chk("R8 valid", int'(bit_out_valid), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One cycle: drive on falling edge, update models at rising edge, compare 1 ns later.
    task automatic tick(input logic v, input logic signed [SW-1:0] s,
                        input logic dv, input logic db);
        logic in_v, in_b, new_bit;
        @(negedge clk);
        smp_valid = v; smp_in = s; drv_v = dv; drv_b = db;
        in_v    = loop_en ? m_txv : dv;
        in_b    = loop_en ? m_bit : db;
        new_bit = (int'(s) > m_acc);   // R1: strictly above the pre-update estimate
        @(posedge clk);
        if (m_txv) apply(m_cnt, m_prev, m_acc, m_bit);   // R2, R3, R4
        if (in_v)  apply(d_cnt, d_prev, d_acc, in_b);    // R6
        if (v) m_bit = new_bit;
        m_txv = v;
        #1;
        chk("R7 bit_out_valid", int'(bit_out_valid), int'(m_txv));
        if (m_txv) chk("R1 bit_out", int'(bit_out), int'(m_bit));
        chk("R2 approx_out", int'(approx_out), m_acc);
        chk("R6 recon_out", int'(recon_out), d_acc);
    endtask

    initial begin
        model_reset();
        do_reset();

        // R1 equal case: sample 0 against estimate 0 gives 0
        tick(1'b1, 12'sd0, 1'b0, 1'b0);
        chk("R1 equal gives 0", int'(bit_out), 0);
        tick(1'b0, 12'sd0, 1'b0, 1'b0);

        // R3 exact ramp: steps 16, 32, 48 from reset
        do_reset();
        for (int k = 0; k < 4; k++) tick(1'b1, 12'sd1000, 1'b0, 1'b0);
        chk("R3 ramp after three steps", int'(approx_out), 96);
        tick(1'b0, 12'sd0, 1'b0, 1'b0);
        tick(1'b0, 12'sd0, 1'b0, 1'b0);

        // vector table, decoder in loop
        do_reset();
        for (int i = 0; i < NVEC; i++) begin
            tick(VEC[i][SW], signed'(VEC[i][SW-1:0]), 1'b0, 1'b0);
        end
        for (int k = 0; k < 30; k++) tick(1'b1, 12'sd1800, 1'b0, 1'b0);   // R4 reach top level
        for (int k = 0; k < 12; k++) tick(1'b1, -12'sd1800, 1'b0, 1'b0);
        chk("R6 loop recon equals approx", int'(recon_out), int'(approx_out));

        // R7 idle: estimate frozen across gap
        tick(1'b0, 12'sd2000, 1'b0, 1'b0);
        tick(1'b0, 12'sd2000, 1'b0, 1'b0);
        tick(1'b0, 12'sd2000, 1'b0, 1'b0);
        chk("R7 frozen", int'(approx_out), m_acc);

        // R5 decoder saturation from the bit input alone
        loop_en = 1'b0;
        for (int k = 0; k < 90; k++) tick(1'b0, 12'sd0, 1'b1, 1'b1);
        chk("R5 clamp high", int'(recon_out), MAXA);
        for (int k = 0; k < 4; k++) tick(1'b0, 12'sd0, 1'b0, 1'b0);
        chk("R6 hold without strobe", int'(recon_out), MAXA);
        for (int k = 0; k < 160; k++) tick(1'b0, 12'sd0, 1'b1, 1'b0);
        chk("R5 clamp low", int'(recon_out), MINA);
        // R4 alternating bits bring the level back down
        for (int k = 0; k < 12; k++) tick(1'b0, 12'sd0, 1'b1, k[0]);

        // R8 mid-run reset, then first step is one unit
        do_reset();
        loop_en = 1'b1;
        tick(1'b1, 12'sd500, 1'b0, 1'b0);
        tick(1'b0, 12'sd0, 1'b0, 1'b0);
        chk("R8 first step after reset", int'(approx_out), UNIT);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule